// File: doc/BRIEF.md
# RTC Tick Divider

This block turns a slow 32 kHz timebase into two periodic enable ticks: one near 1 kHz and one near 1 Hz. The timebase is chosen from two sources, an internal free-running oscillator and a crystal. Each source is modelled as a one-cycle enable on the single system clock. Each tick is a single system-clock pulse. The tick fires when the matching divider counter passes the last count of its ratio.

Each divide ratio is a fixed base plus a small trim offset that software writes. Software can use the trim to tune the tick rate around its nominal value. A newly written trim is held in a shadow field, and a pending flag reports it. The counter adopts the shadow value only when it next wraps. A running interval is therefore never cut short or stretched by a write. The 1 Hz divider also has a halt control that freezes its count.

Software sees one 32-bit configuration word. The word is written through a write strobe with data and read back on a separate read bus.

Top module: `rtc_tick_gen`

## Requirements
- R1: Configuration bit 4 selects the step source. When it is 0, only `osc_int_en` advances the dividers. When it is 1, only `osc_xtal_en` advances them, and the other enable is ignored.
- R2: The 1 kHz divider counts 28 + T steps per tick, where T is the 3-bit trim in configuration bits [2:0].
- R3: The 1 Hz divider counts 31744 + U steps per tick, where U is the 11-bit trim in configuration bits [26:16].
- R4: Each tick output is high for exactly one clock cycle per divider wrap, and is never high on two consecutive cycles.
- R5: A write whose trim field differs from the stored trim sets that divider's pending flag. The 1 kHz flag is read back in bit 15 and the 1 Hz flag in bit 31. A write with an unchanged trim leaves the flag clear. Software cannot set the flag bits by writing them.
- R6: A new trim takes effect only at the next wrap of its divider. The interval in progress completes with the old ratio, and the pending flag clears at that same wrap.
- R7: While halt (configuration bit 28) is 1, the 1 Hz counter holds its value and emits no tick. It then resumes from the held value, so the interval grows by the halted cycles. The 1 kHz divider is not affected by halt.
- R8: After reset the read-back word is 0, both counters are 0, both flags are clear, the ratios are 28 and 31744, and no tick is emitted until the selected source steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_int_en | input | 1 | One-cycle step from the internal 32 kHz oscillator |
| osc_xtal_en | input | 1 | One-cycle step from the 32 kHz crystal |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back, including pending flags |
| tick_khz | output | 1 | 1 kHz tick pulse |
| tick_hz | output | 1 | 1 Hz tick pulse |

## Verification
The hardest case to reach is a trim write that lands in the middle of a running interval. The interval must finish with the old ratio, and the flag must drop exactly at the wrap that loads the new value. The halt case is similar: the 1 Hz interval must stretch by exactly the number of halted cycles. To create these cases, the stimulus waits for an observed tick and then issues the write on the following cycle, well inside the next interval. It then measures the length of every interval between ticks. To make the 1 Hz cases practical, the selected source steps on every clock, so a single 1 Hz interval lasts about 32 thousand cycles.

// File: rtl/rtc_tick_pkg.sv
`timescale 1ns/1ps
package rtc_tick_pkg;
   // configuration word layout
   localparam int unsigned CFG_W        = 32;
   localparam int unsigned KHZ_TRIM_LSB = 0;
   localparam int unsigned SRC_SEL_BIT  = 4;
   localparam int unsigned KHZ_FLAG_BIT = 15;
   localparam int unsigned HZ_TRIM_LSB  = 16;
   localparam int unsigned HZ_HALT_BIT  = 28;
   localparam int unsigned HZ_FLAG_BIT  = 31;

   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_CRYSTAL  = 1'b1
   } src_e;
endpackage

// File: rtl/rtc_src_sel.sv
`timescale 1ns/1ps
module rtc_src_sel
   import rtc_tick_pkg::*;
(
   input  src_e sel,
   input  logic int_en,
   input  logic xtal_en,
   output logic step
);
   always_comb begin
      unique case (sel)
         SRC_CRYSTAL: step = xtal_en;
         default:     step = int_en;
      endcase
   end
endmodule

// File: rtl/rtc_div_core.sv
`timescale 1ns/1ps
module rtc_div_core #(
   parameter int unsigned BASE     = 28,
   parameter int unsigned TRIM_W   = 3,
   parameter bit          HAS_HALT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              halt,
   input  logic              trim_we,
   input  logic [TRIM_W-1:0] trim_wdata,
   output logic [TRIM_W-1:0] trim_shadow,
   output logic              upd_pending,
   output logic              tick
);
   localparam int unsigned RATIO_MAX = BASE + (1 << TRIM_W) - 1;
   localparam int unsigned CNT_W     = $clog2(RATIO_MAX + 1);
   localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(BASE - 1);

   if (BASE < 2) begin : g_bad_base
      $error("rtc_div_core: BASE must be at least 2");
   end
   if (TRIM_W < 1) begin : g_bad_trim
      $error("rtc_div_core: TRIM_W must be at least 1");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [TRIM_W-1:0] active_q;
   logic              run;
   logic              at_last;
   logic              wrap;
   logic              trim_new;

   if (HAS_HALT) begin : g_halt
      assign run = step & ~halt;
   end else begin : g_free
      logic unused_halt;
      assign unused_halt = halt;
      assign run         = step;
   end

   assign at_last  = (cnt_q == (LAST_BASE + CNT_W'(active_q)));
   assign wrap     = run & at_last;
   assign trim_new = trim_we && (trim_wdata != trim_shadow);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         active_q    <= '0;
         trim_shadow <= '0;
         upd_pending <= 1'b0;
         tick        <= 1'b0;
      end else begin
         if (run) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
         end
         if (wrap) begin
            active_q <= trim_shadow;
         end
         if (trim_new) begin
            trim_shadow <= trim_wdata;
         end
         if (trim_new) begin
            upd_pending <= 1'b1;
         end else if (wrap) begin
            upd_pending <= 1'b0;
         end
         tick <= wrap;
      end
   end
endmodule

// File: rtl/rtc_tick_gen.sv
`timescale 1ns/1ps
module rtc_tick_gen
   import rtc_tick_pkg::*;
#(
   parameter int unsigned KHZ_BASE   = 28,
   parameter int unsigned KHZ_TRIM_W = 3,
   parameter int unsigned HZ_BASE    = 31744,
   parameter int unsigned HZ_TRIM_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_int_en,
   input  logic             osc_xtal_en,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             tick_khz,
   output logic             tick_hz
);
   if (KHZ_TRIM_LSB + KHZ_TRIM_W > SRC_SEL_BIT) begin : g_bad_khz_field
      $error("rtc_tick_gen: 1 kHz trim overlaps the source select bit");
   end
   if (HZ_TRIM_LSB + HZ_TRIM_W > HZ_HALT_BIT) begin : g_bad_hz_field
      $error("rtc_tick_gen: 1 Hz trim overlaps the halt bit");
   end

   src_e                  src_q;
   logic                  halt_q;
   logic                  step;
   logic [KHZ_TRIM_W-1:0] khz_trim;
   logic [HZ_TRIM_W-1:0]  hz_trim;
   logic                  khz_pend;
   logic                  hz_pend;
   logic                  unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_INTERNAL;
         halt_q <= 1'b0;
      end else if (cfg_we) begin
         src_q  <= src_e'(cfg_wdata[SRC_SEL_BIT]);
         halt_q <= cfg_wdata[HZ_HALT_BIT];
      end
   end

   rtc_src_sel i_src (
      .sel     (src_q),
      .int_en  (osc_int_en),
      .xtal_en (osc_xtal_en),
      .step    (step)
   );

   rtc_div_core #(
      .BASE     (KHZ_BASE),
      .TRIM_W   (KHZ_TRIM_W),
      .HAS_HALT (1'b0)
   ) i_khz (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .halt        (halt_q),
      .trim_we     (cfg_we),
      .trim_wdata  (cfg_wdata[KHZ_TRIM_LSB +: KHZ_TRIM_W]),
      .trim_shadow (khz_trim),
      .upd_pending (khz_pend),
      .tick        (tick_khz)
   );

   rtc_div_core #(
      .BASE     (HZ_BASE),
      .TRIM_W   (HZ_TRIM_W),
      .HAS_HALT (1'b1)
   ) i_hz (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .halt        (halt_q),
      .trim_we     (cfg_we),
      .trim_wdata  (cfg_wdata[HZ_TRIM_LSB +: HZ_TRIM_W]),
      .trim_shadow (hz_trim),
      .upd_pending (hz_pend),
      .tick        (tick_hz)
   );

   always_comb begin
      cfg_rdata                                = '0;
      cfg_rdata[KHZ_TRIM_LSB +: KHZ_TRIM_W]    = khz_trim;
      cfg_rdata[SRC_SEL_BIT]                   = (src_q == SRC_CRYSTAL);
      cfg_rdata[KHZ_FLAG_BIT]                  = khz_pend;
      cfg_rdata[HZ_TRIM_LSB +: HZ_TRIM_W]      = hz_trim;
      cfg_rdata[HZ_HALT_BIT]                   = halt_q;
      cfg_rdata[HZ_FLAG_BIT]                   = hz_pend;
   end
endmodule

// File: rtl/rtc_tick_chk.sv
`timescale 1ns/1ps
module rtc_tick_chk
   import rtc_tick_pkg::*;
#(
   parameter int unsigned KHZ_TRIM_W = 3,
   parameter int unsigned HZ_TRIM_W  = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_int_en,
   input logic             osc_xtal_en,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             tick_khz,
   input logic             tick_hz
);
   logic sel_step;
   assign sel_step = cfg_rdata[SRC_SEL_BIT] ? osc_xtal_en : osc_int_en;

   p_tick_from_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_khz |-> $past(sel_step));

   p_trim_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> $stable(cfg_rdata[KHZ_TRIM_LSB +: KHZ_TRIM_W]));

   p_khz_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_khz |=> !tick_khz);

   p_hz_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_hz |=> !tick_hz);

   p_khz_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[KHZ_TRIM_LSB +: KHZ_TRIM_W] != cfg_rdata[KHZ_TRIM_LSB +: KHZ_TRIM_W])
      |=> cfg_rdata[KHZ_FLAG_BIT]);

   p_hz_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[HZ_TRIM_LSB +: HZ_TRIM_W] != cfg_rdata[HZ_TRIM_LSB +: HZ_TRIM_W])
      |=> cfg_rdata[HZ_FLAG_BIT]);

   p_khz_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_rdata[KHZ_FLAG_BIT]) |-> tick_khz);

   p_hz_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_rdata[HZ_FLAG_BIT]) |-> tick_hz);

   p_halt_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_rdata[HZ_HALT_BIT]) |-> !tick_hz);
endmodule

bind rtc_tick_gen rtc_tick_chk #(
   .KHZ_TRIM_W (KHZ_TRIM_W),
   .HZ_TRIM_W  (HZ_TRIM_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .osc_int_en  (osc_int_en),
   .osc_xtal_en (osc_xtal_en),
   .cfg_we      (cfg_we),
   .cfg_wdata   (cfg_wdata),
   .cfg_rdata   (cfg_rdata),
   .tick_khz    (tick_khz),
   .tick_hz     (tick_hz)
);

// File: tb/test_rtc_tick_gen.sv
`timescale 1ns/1ps
module test_rtc_tick_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_int_en = 1'b0;
   logic        osc_xtal_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        tick_khz;
   logic        tick_hz;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   bit  int_on = 1'b0;

   int  khz_n = 0, hz_n = 0, khz_per = 0, hz_per = 0;
   int  khz_since = 0, hz_since = 0, dbl_pulse = 0;
   bit  khz_prev = 1'b0, hz_prev = 1'b0;

   localparam int HOLD = 500;

   rtc_tick_gen i_rtc_tick_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_int_en  (osc_int_en),
      .osc_xtal_en (osc_xtal_en),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .tick_khz    (tick_khz),
      .tick_hz     (tick_hz)
   );

   always #2.5 clk = ~clk;

   // step sources: internal steps every cycle when enabled, crystal every third cycle
   initial begin
      int phase = 0;
      forever begin
         @(negedge clk);
         osc_int_en  = int_on;
         osc_xtal_en = (phase == 0);
         phase = (phase == 2) ? 0 : phase + 1;
      end
   end

   // tick interval monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         khz_since = 0; hz_since = 0; khz_prev = 1'b0; hz_prev = 1'b0;
      end else begin
         if (tick_khz) begin
            if (khz_prev) dbl_pulse++;
            khz_per = khz_since; khz_since = 1; khz_n++;
         end else khz_since++;
         if (tick_hz) begin
            if (hz_prev) dbl_pulse++;
            hz_per = hz_since; hz_since = 1; hz_n++;
         end else hz_since++;
         khz_prev = tick_khz;
         hz_prev  = tick_hz;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // called at a negedge, returns at the following negedge
   task automatic wr_cfg(input logic [31:0] val);
      cfg_we = 1'b1; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic wait_khz(input int cnt);
      int tgt;
      @(posedge clk);
      tgt = khz_n + cnt;
      while (khz_n < tgt) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_hz(input int cnt);
      int tgt;
      @(posedge clk);
      tgt = hz_n + cnt;
      while (hz_n < tgt) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      int seen = 0;
      int_on = 1'b0;
      rst_n  = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) begin
         @(negedge clk);
         if (tick_khz || tick_hz) seen++;
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(cfg_rdata == 32'h0, "R8", "read-back after reset", cfg_rdata, 0);
      check(!tick_khz && !tick_hz, "R8", "no tick without steps", {tick_khz, tick_hz}, 0);
      int_on = 1'b1;
   endtask

   task automatic t_khz_default();
      wait_khz(3);
      check(khz_per == 28, "R2", "default 1 kHz interval", khz_per, 28);
   endtask

   task automatic t_khz_trim();
      wr_cfg(32'h0000_0007);
      check(cfg_rdata[15] == 1'b1, "R5", "1 kHz pending after trim write", cfg_rdata[15], 1);
      wait_khz(1);
      check(khz_per == 28, "R6", "interval in progress keeps old ratio", khz_per, 28);
      check(cfg_rdata[15] == 1'b0, "R6", "1 kHz pending clears at wrap", cfg_rdata[15], 0);
      wait_khz(1);
      check(khz_per == 35, "R2", "trimmed 1 kHz interval", khz_per, 35);
      wr_cfg(32'h8000_8007);
      check(cfg_rdata == 32'h0000_0007, "R5", "unchanged trim and flag bits written", cfg_rdata, 32'h7);
   endtask

   task automatic t_src_select();
      wr_cfg(32'h0000_0017);
      wait_khz(2);
      check(khz_per == 105, "R1", "crystal source, internal ignored", khz_per, 105);
      wr_cfg(32'h0000_0007);
      wait_khz(2);
      check(khz_per == 35, "R1", "back on internal source", khz_per, 35);
   endtask

   task automatic t_hz_trim();
      do_reset();
      int_on = 1'b1;
      wait_hz(1);
      wr_cfg(32'h07FF_0000);
      check(cfg_rdata == 32'h87FF_0000, "R5", "1 Hz pending after trim write", cfg_rdata, 32'h87FF0000);
      wait_hz(1);
      check(hz_per == 31744, "R3", "default 1 Hz interval (old ratio kept, R6)", hz_per, 31744);
      check(cfg_rdata[31] == 1'b0, "R6", "1 Hz pending clears at wrap", cfg_rdata[31], 0);
   endtask

   task automatic t_hz_halt();
      int h0, k0;
      wr_cfg(32'h17FF_0000);
      @(posedge clk);
      h0 = hz_n; k0 = khz_n;
      repeat (HOLD) @(posedge clk);
      check(hz_n == h0, "R7", "no 1 Hz tick while halted", hz_n - h0, 0);
      check(khz_n - k0 >= 17, "R7", "1 kHz keeps running during halt", khz_n - k0, 17);
      check(cfg_rdata[28] == 1'b1, "R7", "halt read-back", cfg_rdata[28], 1);
      @(negedge clk);
      wr_cfg(32'h07FF_0000);
      wait_hz(1);
      check(hz_per == 33791 + HOLD + 2, "R3", "trimmed interval stretched by halt (R7)",
            hz_per, 33791 + HOLD + 2);
   endtask

   task automatic t_width();
      check(dbl_pulse == 0, "R4", "tick high on consecutive cycles", dbl_pulse, 0);
   endtask

   initial begin
      t_reset();
      t_khz_default();
      t_khz_trim();
      t_src_select();
      t_hz_trim();
      t_hz_halt();
      t_width();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R4 watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule